// File: doc/BRIEF.md
# DAC Latched Write Sequencer

This block sits between a sample source and an 8-bit parallel digital-to-analog converter whose input register is a transparent latch opened by two active-low enables. A host offers a sample with a valid/ready handshake. On acceptance the block places the code on the converter's data bus and leaves it there for a set number of clocks, so that the bus has stopped switching before the latch opens. Only then does it drive both enables low together for a set strobe width. After the enables return high it waits a settling interval for the analog output before it takes the next sample.

A mode input, sampled when a sample is accepted, picks straight binary pass-through or conversion of a signed two's-complement sample to offset binary, which inverts the most significant bit. The enables, the data bus, the ready flag and the settled pulse all leave the block straight from flip-flops, so they cannot glitch. Setup length, strobe width and settling length are parameters. The defaults are 2, 3 and 100 clocks, and 100 clocks is 1 µs at 100 MHz.

Top module: `dac_latch_writer`

## Requirements
- R1: Reset is synchronous on rst_n low. During and after reset, ceN and csN are 1, inReady is 1 and settled is 0. dacD is 8'h80 if offsetMode is 1 at the reset edge, and 8'h00 if it is 0.
- R2: A sample is accepted on a rising clock edge where inValid and inReady are both 1. inReady is 0 from the cycle after that edge.
- R3: With offsetMode 0 at acceptance, dacD becomes inData unchanged. With offsetMode 1, dacD becomes inData with bit 7 inverted. Examples: 8'h80 gives 8'h00, 8'h7F gives 8'hFF, 8'h00 gives 8'h80. The new value appears in the cycle after the accepting edge.
- R4: dacD changes only on an accepting edge. Changes of inData or offsetMode at any other time have no effect on it.
- R5: ceN and csN fall exactly SETUP_CYC clocks after the accepting edge, so dacD has been stable for SETUP_CYC cycles when the latch opens.
- R6: ceN and csN stay low for exactly STROBE_CYC cycles, then return to 1.
- R7: inReady returns to 1 exactly SETTLE_CYC clocks after the enables return high. settled is a one-cycle pulse in that same cycle and is 0 at all other times.
- R8: A valid sample offered while inReady is 0 is not taken and does not disturb dacD. If inValid is held, the sample is accepted on the first edge on which inReady is 1.
- R9: ceN and csN are always equal, and neither is ever 0 while inReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inData | input | 8 | Sample offered by the host |
| inValid | input | 1 | Sample offer strobe |
| inReady | output | 1 | Block can accept a sample |
| offsetMode | input | 1 | 1: signed-to-offset-binary conversion, 0: pass-through |
| dacD | output | 8 | Converter data bus |
| ceN | output | 1 | Converter latch enable, active low |
| csN | output | 1 | Converter select, active low |
| settled | output | 1 | One-cycle pulse when the settling wait ends |

## Verification
Codes at both ends of the range and on each side of mid-scale (00, 7F, 80, FF) are written in both modes. This separates a correct inversion of the top bit from pass-through or a full inversion. Single writes with a gap between them check the exact setup, strobe and settling counts against a timeline model. A valid held high through a busy phase, with new data and a flipped mode during that phase, shows whether a busy offer is wrongly taken or lost, and whether the data bus reacts to anything other than an acceptance. Reset is applied under both modes to check the mid-scale and zero reset codes.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;
  // Command from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture a new sample onto the bus this edge
  } dacWrCmd_t;
endpackage

// File: rtl/dac_wr_path.sv
module dac_wr_path
  import dac_wr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dacWrCmd_t         cmd,
  input  logic              offsetMode,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] dacD
);
  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] codeNext;

  // Offset binary: flip the sign bit of the two's-complement sample
  always_comb begin
    codeNext = inData;
    if (offsetMode) codeNext[DATA_W-1] = ~inData[DATA_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        dacD <= offsetMode ? MID_CODE : '0;
    else if (cmd.load) dacD <= codeNext;
  end
endmodule

// File: rtl/dac_wr_ctrl.sv
module dac_wr_ctrl
  import dac_wr_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int SETTLE_CYC = 100
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      inValid,
  output logic      inReady,
  output dacWrCmd_t cmd,
  output logic      ceN,
  output logic      csN,
  output logic      settled
);
  localparam int MAX_A = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_C = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_SETTLE} wrState_t;

  wrState_t   state;
  logic [CNT_W-1:0] cnt;

  always_comb cmd.load = (state == ST_IDLE) && inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      inReady <= 1'b1;
      ceN     <= 1'b1;
      csN     <= 1'b1;
      settled <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          settled <= 1'b0;
          if (cmd.load) begin
            state   <= ST_SETUP;
            cnt     <= CNT_W'(SETUP_CYC - 1);
            inReady <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            state <= ST_STROBE;
            cnt   <= CNT_W'(STROBE_CYC - 1);
            ceN   <= 1'b0;
            csN   <= 1'b0;
          end else cnt <= cnt - 1'b1;
        end
        ST_STROBE: begin
          if (cnt == '0) begin
            state <= ST_SETTLE;
            cnt   <= CNT_W'(SETTLE_CYC - 1);
            ceN   <= 1'b1;
            csN   <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        default: begin
          if (cnt == '0) begin
            state   <= ST_IDLE;
            inReady <= 1'b1;
            settled <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/dac_latch_writer.sv
module dac_latch_writer
  import dac_wr_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int SETTLE_CYC = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              offsetMode,
  output logic [DATA_W-1:0] dacD,
  output logic              ceN,
  output logic              csN,
  output logic              settled
);
  dacWrCmd_t cmd;

  dac_wr_ctrl #(
    .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .cmd(cmd), .ceN(ceN), .csN(csN), .settled(settled)
  );

  dac_wr_path #(.DATA_W(DATA_W)) path_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .offsetMode(offsetMode),
    .inData(inData), .dacD(dacD)
  );
endmodule

// File: rtl/dac_wr_checker.sv
module dac_wr_checker #(
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int SETTLE_CYC = 100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic              inReady,
  input logic [DATA_W-1:0] dacD,
  input logic              ceN,
  input logic              csN,
  input logic              settled
);
  logic [31:0] sinceAcc;

  always_ff @(posedge clk) begin
    if (!rst_n)                  sinceAcc <= '0;
    else if (inValid && inReady) sinceAcc <= '0;
    else if (sinceAcc != '1)     sinceAcc <= sinceAcc + 1;
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> !inReady);                                        // R2
  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !inReady |=> $stable(dacD));                                               // R4
  AST_SETUP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ceN) |-> (sinceAcc == 32'(SETUP_CYC)));                              // R5
  AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ceN) |-> (sinceAcc == 32'(SETUP_CYC + STROBE_CYC)));                 // R6
  AST_SETTLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inReady) |-> (sinceAcc == 32'(SETUP_CYC + STROBE_CYC + SETTLE_CYC))); // R7
  AST_SETTLED_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    settled |=> !settled);                                                     // R7
  AST_SETTLED_READY: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> inReady);                                                      // R7
  AST_ENABLES_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    ceN == csN);                                                               // R9
  AST_NO_STROBE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    inReady |-> (ceN && csN));                                                 // R9
endmodule

bind dac_latch_writer dac_wr_checker #(
  .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC),
  .STROBE_CYC(STROBE_CYC), .SETTLE_CYC(SETTLE_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
  .dacD(dacD), .ceN(ceN), .csN(csN), .settled(settled)
);

// File: tb/dac_latch_writer_tb_top.sv
`timescale 1ns/1ps
module dac_latch_writer_tb_top;
  localparam int S = 2, W = 3, T = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       inValid = 1'b0;
  logic       offsetMode = 1'b0;
  logic       inReady, ceN, csN, settled;
  logic [7:0] dacD;

  int checks = 0, fails = 0;
  bit started = 0, accFlag = 0, finished = 0;

  // timeline reference model
  bit   mReady = 1, mStrobe = 1, mSettled = 0;
  logic [7:0] mD = 8'h00;
  int   t = -1;

  always #5 clk = ~clk;

  dac_latch_writer dut_i (
    .clk(clk), .rst_n(rst_n), .inData(inData), .inValid(inValid),
    .inReady(inReady), .offsetMode(offsetMode), .dacD(dacD),
    .ceN(ceN), .csN(csN), .settled(settled)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    started <= 1;
    accFlag = 0;
    if (!rst_n) begin
      mReady = 1; mStrobe = 1; mSettled = 0; t = -1;
      mD = offsetMode ? 8'h80 : 8'h00;                // R1
    end else if (t < 0) begin
      mSettled = 0;
      if (inValid && mReady) begin                    // R2, R8
        mD = offsetMode ? (inData ^ 8'h80) : inData;  // R3
        mReady = 0; t = 0; accFlag = 1;
      end
    end else begin
      t++;
      mStrobe = !(t >= S && t < S + W);               // R5, R6
      if (t == S + W + T) begin                       // R7
        mReady = 1; mSettled = 1; t = -1;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started && !finished) begin
      check("R3/R4 dacD", dacD, mD);
      check("R5/R6 ceN", {7'd0, ceN}, {7'd0, mStrobe});
      check("R9 csN", {7'd0, csN}, {7'd0, mStrobe});
      check("R2/R7 inReady", {7'd0, inReady}, {7'd0, mReady});
      check("R7 settled", {7'd0, settled}, {7'd0, mSettled});
    end
  end

  task automatic sendWrite(logic [7:0] d, bit mode, bit keepValid);
    @(negedge clk);
    inData = d; offsetMode = mode; inValid = 1'b1;
    do begin @(posedge clk); #1; end while (!accFlag);
    if (!keepValid) begin @(negedge clk); inValid = 1'b0; end
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (!mReady);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset dacD straight", dacD, 8'h00);
    check("R1 reset ceN", {7'd0, ceN}, 8'd1);
    check("R1 reset inReady", {7'd0, inReady}, 8'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // straight mode corners (R3)
    sendWrite(8'h00, 0, 0); waitIdle();
    sendWrite(8'hFF, 0, 0); waitIdle();
    check("R3 straight FF", dacD, 8'hFF);
    sendWrite(8'h7F, 0, 0); waitIdle();
    sendWrite(8'h80, 0, 0); waitIdle();
    check("R3 straight 80", dacD, 8'h80);
    // offset mode corners (R3)
    sendWrite(8'h80, 1, 0); waitIdle();
    check("R3 offset 80->00", dacD, 8'h00);
    sendWrite(8'h7F, 1, 0); waitIdle();
    check("R3 offset 7F->FF", dacD, 8'hFF);
    sendWrite(8'h00, 1, 0); waitIdle();
    sendWrite(8'hFF, 1, 0); waitIdle();
    check("R3 offset FF->7F", dacD, 8'h7F);

    // busy offer held, data and mode change mid-write (R4, R8)
    sendWrite(8'h12, 0, 1);
    @(negedge clk); inData = 8'h34; offsetMode = 1'b1;
    repeat (20) @(negedge clk);
    check("R8 busy offer ignored", dacD, 8'h12);
    check("R4 mode change ignored", dacD, 8'h12);
    do begin @(posedge clk); #1; end while (!accFlag);
    @(negedge clk); inValid = 1'b0;
    check("R8 held offer taken", dacD, 8'hB4);
    waitIdle();

    // reset under offset mode (R1)
    @(negedge clk); offsetMode = 1'b1; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset dacD offset", dacD, 8'h80);
    check("R1 reset settled", {7'd0, settled}, 8'd0);
    rst_n = 1'b1;
    sendWrite(8'hC0, 1, 0); waitIdle();
    check("R3 offset C0->40", dacD, 8'h40);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule